// File: doc/BRIEF.md
# Wait-For-Interrupt Sleep and Wake Controller

This block sits next to a simple in-order core and handles the wait-for-interrupt instruction. When the core retires such an instruction, the controller stalls instruction issue and waits for the in-flight instructions to finish. Once the pipeline is empty, it drops the enable of a glitch-free clock gate on the core clock. The core stays powered, so no state is lost.

The controller runs on the free-running clock, so it keeps watching the interrupt lines while the core clock is off. It wakes when any interrupt line is both pending and locally enabled. It then reopens the clock gate, holds issue for one more cycle, and reports the action to the external trap logic.

The global interrupt enable does not affect waking. It only picks the action at wake: take the trap, or resume at the next instruction. In both cases the reported address is the captured instruction address plus 4. A debug halt or a reset returns the block to normal running from any state.

Top module: `wfi_sleep_ctrl`

## Requirements
- R1: After synchronous reset, issue_stall, sleeping and wake_valid are 0, and gclk follows clk (one rising edge per clk cycle).
- R2: When wfi_retire is seen in the running state, issue_stall is 1 from the next cycle on. It stays 1 with sleeping at 0 for as long as pipe_empty is 0.
- R3: When pipe_empty is 1 during draining and no interrupt qualifies, sleeping goes to 1 on the next cycle. From then on, gclk has no rising edge while sleeping is 1.
- R4: An interrupt qualifies only when bit i of irq_pending and bit i of irq_enable are both 1 for the same i. Pending without enable, or enable without pending, leaves the block asleep. The value of global_ie does not affect waking.
- R5: If an interrupt qualifies when draining completes, the block goes straight to the wake cycle and sleeping never becomes 1.
- R6: A wake lasts exactly one cycle with wake_valid at 1. gclk rises again on the next clk edge, and issue_stall is 0 on the cycle after the wake cycle.
- R7: wake_trap is 1 during the wake cycle if global_ie was 1 when the wake was decided, and 0 otherwise (resume without a trap).
- R8: During the wake cycle, resume_pc equals the wfi_pc sampled together with wfi_retire, plus 4. Later changes of wfi_pc have no effect on it.
- R9: dbg_halt at 1 forces the running state on the next cycle from any state: issue_stall, sleeping and wake_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_retire | input | 1 | A wait-for-interrupt instruction retires this cycle |
| wfi_pc | input | XLEN | Address of that instruction |
| pipe_empty | input | 1 | No instruction is in flight |
| irq_pending | input | NIRQ | Pending interrupt lines |
| irq_enable | input | NIRQ | Per-line interrupt enables |
| global_ie | input | 1 | Global interrupt enable |
| dbg_halt | input | 1 | Debug halt request |
| issue_stall | output | 1 | Blocks instruction issue |
| sleeping | output | 1 | Core clock is gated off |
| gclk | output | 1 | Gated core clock |
| wake_valid | output | 1 | One-cycle wake report |
| wake_trap | output | 1 | 1 = take trap, 0 = resume |
| resume_pc | output | XLEN | Return or resume address |

## Verification
A wrong state shows up at the ports within one clk cycle. A stuck drain or sleep state leaves issue_stall at 1 after the wake condition. A missed sleep entry lets gclk keep rising. A wrong capture or a wrong trap choice appears on resume_pc or wake_trap during the single wake_valid cycle. The bench counts gclk edges, so a clock that is gated too early or reopened too late shows up as a wrong count.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } wfi_state_e;

    localparam int unsigned INSN_BYTES = 4;

    typedef struct packed {
        logic issue_stall;
        logic clk_en_req;
        logic sleeping;
        logic wake_valid;
    } wfi_ctl_t;

    function automatic wfi_ctl_t decode_state(input wfi_state_e st);
        wfi_ctl_t c;
        c.issue_stall = (st != ST_RUN);
        c.clk_en_req  = (st != ST_SLEEP);
        c.sleeping    = (st == ST_SLEEP);
        c.wake_valid  = (st == ST_WAKE);
        return c;
    endfunction
endpackage

// File: rtl/wfi_wake_detect.sv
module wfi_wake_detect #(
    parameter int NIRQ = 16
) (
    input  logic [NIRQ-1:0] irq_pending,
    input  logic [NIRQ-1:0] irq_enable,
    output logic            wake_any
);
    logic [NIRQ-1:0] qual;

    for (genvar i = 0; i < NIRQ; i++) begin : g_qual
        assign qual[i] = irq_pending[i] & irq_enable[i];
    end

    assign wake_any = |qual;
endmodule

// File: rtl/wfi_clk_gate.sv
module wfi_clk_gate (
    input  logic clk,
    input  logic en_req,
    output logic gclk
);
    logic en_l;

    // Enable passes only while clk is low, so gclk cannot glitch.
    always_latch begin
        if (!clk) en_l = en_req;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/wfi_seq_fsm.sv
module wfi_seq_fsm
    import wfi_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wfi_retire,
    input  logic [XLEN-1:0] wfi_pc,
    input  logic            pipe_empty,
    input  logic            wake_any,
    input  logic            global_ie,
    input  logic            dbg_halt,
    output wfi_ctl_t        ctl,
    output logic            wake_trap,
    output logic [XLEN-1:0] resume_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    wfi_state_e      state_q, state_d;
    logic [XLEN-1:0] pc_q;
    logic            trap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (wfi_retire) state_d = ST_DRAIN;
            ST_DRAIN: if (pipe_empty) state_d = wake_any ? ST_WAKE : ST_SLEEP;
            ST_SLEEP: if (wake_any)   state_d = ST_WAKE;
            ST_WAKE:  state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
        if (dbg_halt) state_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
            trap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && wfi_retire && !dbg_halt) pc_q <= wfi_pc;
            if (state_d == ST_WAKE && state_q != ST_WAKE) trap_q <= global_ie;
        end
    end

    assign ctl       = decode_state(state_q);
    assign wake_trap = ctl.wake_valid & trap_q;
    assign resume_pc = pc_q + STEP;

    assert_stall_on_retire_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && wfi_retire && !dbg_halt) |=> ctl.issue_stall);

    assert_drain_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && !pipe_empty && !dbg_halt) |=> (state_q == ST_DRAIN));

    assert_stay_asleep_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && !wake_any && !dbg_halt) |=> ctl.sleeping);

    assert_skip_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && pipe_empty && wake_any && !dbg_halt) |=> ctl.wake_valid);

    assert_wake_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.wake_valid |=> !ctl.wake_valid);

    assert_trap_choice_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && wake_any && !dbg_halt) |=> (wake_trap == $past(global_ie)));

    assert_debug_run_R9: assert property (@(posedge clk) disable iff (rst)
        dbg_halt |=> (!ctl.issue_stall && !ctl.sleeping));
endmodule

// File: rtl/wfi_sleep_ctrl.sv
module wfi_sleep_ctrl
    import wfi_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NIRQ = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wfi_retire,
    input  logic [XLEN-1:0] wfi_pc,
    input  logic            pipe_empty,
    input  logic [NIRQ-1:0] irq_pending,
    input  logic [NIRQ-1:0] irq_enable,
    input  logic            global_ie,
    input  logic            dbg_halt,
    output logic            issue_stall,
    output logic            sleeping,
    output logic            gclk,
    output logic            wake_valid,
    output logic            wake_trap,
    output logic [XLEN-1:0] resume_pc
);
    logic     wake_any;
    wfi_ctl_t ctl;

    wfi_wake_detect #(.NIRQ(NIRQ)) i_detect (
        .irq_pending (irq_pending),
        .irq_enable  (irq_enable),
        .wake_any    (wake_any)
    );

    wfi_seq_fsm #(.XLEN(XLEN)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .wfi_retire (wfi_retire),
        .wfi_pc     (wfi_pc),
        .pipe_empty (pipe_empty),
        .wake_any   (wake_any),
        .global_ie  (global_ie),
        .dbg_halt   (dbg_halt),
        .ctl        (ctl),
        .wake_trap  (wake_trap),
        .resume_pc  (resume_pc)
    );

    wfi_clk_gate i_gate (
        .clk    (clk),
        .en_req (ctl.clk_en_req),
        .gclk   (gclk)
    );

    assign issue_stall = ctl.issue_stall;
    assign sleeping    = ctl.sleeping;
    assign wake_valid  = ctl.wake_valid;
endmodule

// File: tb/test_wfi_sleep_ctrl.sv
module test_wfi_sleep_ctrl;
    localparam int XLEN = 32;
    localparam int NIRQ = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wfi_retire = 1'b0;
    logic [XLEN-1:0] wfi_pc = '0;
    logic            pipe_empty = 1'b0;
    logic [NIRQ-1:0] irq_pending = '0;
    logic [NIRQ-1:0] irq_enable = '0;
    logic            global_ie = 1'b0;
    logic            dbg_halt = 1'b0;
    logic            issue_stall, sleeping, gclk, wake_valid, wake_trap;
    logic [XLEN-1:0] resume_pc;

    int checks = 0;
    int errors = 0;
    int gcnt = 0;

    always #4 clk = ~clk;
    always @(posedge gclk) gcnt++;

    wfi_sleep_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ)) i_wfi_sleep_ctrl (
        .clk(clk), .rst(rst), .wfi_retire(wfi_retire), .wfi_pc(wfi_pc),
        .pipe_empty(pipe_empty), .irq_pending(irq_pending), .irq_enable(irq_enable),
        .global_ie(global_ie), .dbg_halt(dbg_halt), .issue_stall(issue_stall),
        .sleeping(sleeping), .gclk(gclk), .wake_valid(wake_valid),
        .wake_trap(wake_trap), .resume_pc(resume_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Retire WFI, drain two cycles, then allow sleep entry.
    task automatic go_drain(input logic [XLEN-1:0] pc);
        wfi_retire = 1'b1; wfi_pc = pc; pipe_empty = 1'b0;
        tick();
        wfi_retire = 1'b0;
        check("R2 stall after retire", issue_stall, 1);
        tick();
        check("R2 stall while draining", issue_stall, 1);
        check("R2 not asleep while draining", sleeping, 0);
        pipe_empty = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        check("R1 reset stall", issue_stall, 0);
        check("R1 reset sleeping", sleeping, 0);
        check("R1 reset wake_valid", wake_valid, 0);
        gcnt = 0;
        repeat (3) tick();
        check("R1 gclk running", gcnt, 3);
    endtask

    task automatic t_sleep_trap();
        global_ie = 1'b1;
        go_drain(32'h0000_1000);
        check("R3 sleeping", sleeping, 1);
        gcnt = 0;
        wfi_pc = 32'hDEAD_0000;
        irq_pending = 16'h0008; irq_enable = 16'h0020;
        repeat (4) tick();
        check("R3 gclk stopped", gcnt, 0);
        check("R4 no wake on unmatched bits", sleeping, 1);
        check("R4 still stalled", issue_stall, 1);
        irq_enable = 16'h0028;
        tick();
        check("R6 wake_valid", wake_valid, 1);
        check("R6 left sleep", sleeping, 0);
        check("R7 trap with global_ie=1", wake_trap, 1);
        check("R8 resume_pc", resume_pc, 32'h0000_1004);
        tick();
        check("R6 wake one cycle", wake_valid, 0);
        check("R6 issue resumes", issue_stall, 0);
        check("R6 gclk back", gcnt, 1);
        irq_pending = '0; irq_enable = '0; pipe_empty = 1'b0;
    endtask

    task automatic t_resume();
        global_ie = 1'b0;
        go_drain(32'h0000_2FFC);
        check("R3 sleeping", sleeping, 1);
        irq_enable = 16'h8000;
        repeat (2) tick();
        check("R4 enable alone no wake", sleeping, 1);
        irq_pending = 16'h8000;
        tick();
        check("R4 wake with global_ie=0", wake_valid, 1);
        check("R7 resume without trap", wake_trap, 0);
        check("R8 resume_pc", resume_pc, 32'h0000_3000);
        tick();
        check("R6 issue resumes", issue_stall, 0);
        irq_pending = '0; irq_enable = '0; pipe_empty = 1'b0;
    endtask

    task automatic t_skip();
        global_ie = 1'b1;
        irq_pending = 16'h0001; irq_enable = 16'h0001;
        gcnt = 0;
        go_drain(32'h0000_0040);
        check("R5 wake without sleep", wake_valid, 1);
        check("R5 never asleep", sleeping, 0);
        check("R5 trap", wake_trap, 1);
        check("R5 gclk never stopped", gcnt, 3);
        tick();
        check("R5 issue resumes", issue_stall, 0);
        irq_pending = '0; irq_enable = '0; pipe_empty = 1'b0;
    endtask

    task automatic t_debug();
        go_drain(32'h0000_0100);
        check("R9 setup asleep", sleeping, 1);
        dbg_halt = 1'b1;
        tick();
        dbg_halt = 1'b0;
        check("R9 debug exits sleep", sleeping, 0);
        check("R9 debug clears stall", issue_stall, 0);
        check("R9 no wake report", wake_valid, 0);
        wfi_retire = 1'b1; pipe_empty = 1'b0; tick();
        wfi_retire = 1'b0;
        dbg_halt = 1'b1; tick(); dbg_halt = 1'b0;
        check("R9 debug exits drain", issue_stall, 0);
        pipe_empty = 1'b0;
    endtask

    initial begin
        tick();
        t_reset();
        t_sleep_trap();
        t_resume();
        t_skip();
        t_debug();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule